// File: doc/BRIEF.md
# Dual-Port Double-Data-Rate Burst-of-Two Memory

This block is an on-chip storage array with one port for incoming write data and a separate port for outgoing read data. It suits traffic that alternates reads and writes back to back. Every rising clock edge samples two active-low strobes, one for reading and one for writing. Either strobe may be active alone, both may be active together, or neither. A read takes its address on the rising edge. A write takes its address on the falling edge that follows. Each access carries two data beats, the first on the rising edge and the second on the falling edge.

Read data comes back a fixed number of cycles after the command. That number is set by a parameter. A cycle without read data is either released (output enable low) or driven to all zeros. The choice depends on a two-bit termination-mode input sampled with the command. The output is a plain data bus plus an enable, with no three-state driver, so the block stays synthesizable. Each stored word holds both beats of one access, and beat order is kept in both directions.

Top module: `sio_ddr_sram`

## Requirements
- R1: A rising edge with both strobes high (no-op) leaves the array unchanged, whatever the address and data inputs hold.
- R2: A write (wr_n low at a rising edge) stores wr_data sampled at that rising edge as beat 0, and wr_data sampled at the following falling edge as beat 1. The address used is wr_addr at that falling edge.
- R3: A read (rd_n low at rising edge n) drives rd_oe high for cycle n+RD_LAT. rd_data shows beat 0 at rd_addr while clk is high and beat 1 while clk is low.
- R4: A read and a write in the same cycle at different addresses both complete.
- R5: A read and a write in the same cycle at the same address return the contents held before that write.
- R6: With term_mode 2'b00 at a no-op or write-only edge n, rd_oe is low and rd_data is zero for cycle n+RD_LAT.
- R7: With term_mode 2'b01 or 2'b10 at a no-op or write-only edge n, rd_oe is high and rd_data is all zeros for cycle n+RD_LAT.
- R8: term_mode 2'b11 behaves exactly like 2'b00.
- R9: While rst_n is low, and for the first RD_LAT cycles after it rises, rd_oe is low and rd_data is zero. Array contents survive reset.
- R10: Consecutive reads return in command order, one every cycle, each exactly RD_LAT cycles after its command.
- R11: The idle rule for each cycle is set by the term_mode sampled with its own command. A read ignores term_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising and falling edges both carry data |
| rst_n | input | 1 | Synchronous active-low reset of the control and output pipeline |
| rd_n | input | 1 | Active-low read strobe, sampled on the rising edge |
| wr_n | input | 1 | Active-low write strobe, sampled on the rising edge |
| rd_addr | input | ADDR_W | Read word address, sampled on the rising edge |
| wr_addr | input | ADDR_W | Write word address, sampled on the falling edge |
| wr_data | input | BEAT_W | Write beat: beat 0 at the rising edge, beat 1 at the falling edge |
| term_mode | input | 2 | Idle-cycle rule: 00/11 release, 01/10 drive zeros |
| rd_data | output | BEAT_W | Read beat: beat 0 while clk is high, beat 1 while clk is low |
| rd_oe | output | 1 | High when rd_data is being driven |

## Verification
The hardest case to reach from the ports is a combined read and write to one address in the same cycle. In that case the array must answer the read before the falling-edge write lands, and the result only shows RD_LAT cycles later, mixed in with the output slots of neighbouring commands. The stimulus table puts that collision between writes and reads to other addresses. It also changes term_mode from one command to the next, so every output slot has a different expected rule. The bench's own model applies each write only after recording the read value for that step. A later read of the same address then confirms that the write did land.

// File: rtl/sio_ddr_pkg.sv
`timescale 1ns/1ps
package sio_ddr_pkg;

  // What the read-data port does during one output cycle
  typedef enum logic [1:0] {
    OUT_HIZ  = 2'd0,
    OUT_ZERO = 2'd1,
    OUT_DATA = 2'd2
  } out_kind_e;

  // Modes 01 and 10 ask for a driven-low idle cycle; 00 and 11 release it
  function automatic logic idle_drives_low(input logic [1:0] mode);
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction

  // Output behaviour scheduled by one command edge
  function automatic out_kind_e slot_kind(input logic rd_n, input logic [1:0] mode);
    if (!rd_n)                  return OUT_DATA;
    else if (idle_drives_low(mode)) return OUT_ZERO;
    else                        return OUT_HIZ;
  endfunction

endpackage

// File: rtl/sio_wr_port.sv
`timescale 1ns/1ps
module sio_wr_port #(
  parameter int ADDR_W = 4,
  parameter int BEAT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_n,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BEAT_W-1:0]   wr_data,
  output logic                commit_en,
  output logic [ADDR_W-1:0]   commit_addr,
  output logic [2*BEAT_W-1:0] commit_word
);
  logic              pend_q;
  logic [BEAT_W-1:0] beat0_q;

  // First beat and the request flag are taken on the rising edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      beat0_q <= '0;
    end else begin
      pend_q  <= !wr_n;
      beat0_q <= wr_data;
    end
  end

  // Second beat and address are live at the falling edge, where the array commits
  assign commit_en   = pend_q;
  assign commit_addr = wr_addr;
  assign commit_word = {wr_data, beat0_q};
endmodule

// File: rtl/sio_mem_array.sv
`timescale 1ns/1ps
module sio_mem_array #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] cells [DEPTH];

  // Writes land on the falling edge, after the rising-edge read of the same cycle
  always_ff @(negedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/sio_rd_pipe.sv
`timescale 1ns/1ps
module sio_rd_pipe
  import sio_ddr_pkg::*;
#(
  parameter int BEAT_W = 8,
  parameter int RL     = 3,
  localparam int WORD_W = 2 * BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] rword,
  output logic [BEAT_W-1:0] rd_data,
  output logic              rd_oe,
  output out_kind_e         head_kind,
  output out_kind_e         tail_kind,
  output out_kind_e         out_kind
);
  out_kind_e         kind_q [RL];
  logic [WORD_W-1:0] word_q [RL];
  logic [WORD_W-1:0] out_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < RL; k++) begin
        kind_q[k] <= OUT_HIZ;
        word_q[k] <= '0;
      end
      out_kind <= OUT_HIZ;
      out_word <= '0;
    end else begin
      kind_q[0] <= slot_kind(rd_n, mode);
      word_q[0] <= rd_n ? '0 : rword;
      for (int k = 1; k < RL; k++) begin
        kind_q[k] <= kind_q[k-1];
        word_q[k] <= word_q[k-1];
      end
      out_kind <= kind_q[RL-1];
      out_word <= word_q[RL-1];
    end
  end

  assign head_kind = kind_q[0];
  assign tail_kind = kind_q[RL-1];
  assign rd_oe     = (out_kind != OUT_HIZ);
  // Beat 0 in the high phase, beat 1 in the low phase
  assign rd_data   = (out_kind == OUT_DATA)
                   ? (clk ? out_word[BEAT_W-1:0] : out_word[WORD_W-1:BEAT_W])
                   : '0;
endmodule

// File: rtl/sio_ddr_sram.sv
`timescale 1ns/1ps
module sio_ddr_sram
  import sio_ddr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BEAT_W = 8,
  parameter int RD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BEAT_W-1:0] wr_data,
  input  logic [1:0]        term_mode,
  output logic [BEAT_W-1:0] rd_data,
  output logic              rd_oe
);
  localparam int WORD_W = 2 * BEAT_W;

  logic              wr_commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [WORD_W-1:0] commit_word;
  logic [WORD_W-1:0] read_word;
  out_kind_e         head_kind;
  out_kind_e         tail_kind;
  out_kind_e         out_kind;

  sio_wr_port #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_en(wr_commit), .commit_addr(commit_addr), .commit_word(commit_word)
  );

  sio_mem_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .we(wr_commit), .waddr(commit_addr), .wdata(commit_word),
    .raddr(rd_addr), .rdata(read_word)
  );

  sio_rd_pipe #(.BEAT_W(BEAT_W), .RL(RD_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .mode(term_mode), .rword(read_word),
    .rd_data(rd_data), .rd_oe(rd_oe),
    .head_kind(head_kind), .tail_kind(tail_kind), .out_kind(out_kind)
  );
endmodule

// File: rtl/sio_ddr_sram_chk.sv
`timescale 1ns/1ps
module sio_ddr_sram_chk
  import sio_ddr_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_n,
  input logic         wr_n,
  input logic [1:0]   term_mode,
  input logic         rd_oe,
  input logic [W-1:0] rd_data,
  input logic         wr_commit,
  input out_kind_e    head_kind,
  input out_kind_e    tail_kind,
  input out_kind_e    out_kind
);
  a_r1_nop_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |=> !wr_commit);

  a_r3_read_scheduled: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |=> (head_kind == OUT_DATA));

  a_r6_hiz_released: assert property (@(posedge clk) disable iff (!rst_n)
    (out_kind == OUT_HIZ) |-> (!rd_oe && rd_data == '0));

  a_r7_zero_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (out_kind == OUT_ZERO) |-> (rd_oe && rd_data == '0));

  a_r8_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && term_mode == 2'b11) |=> (head_kind == OUT_HIZ));

  a_r10_tail_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (out_kind == $past(tail_kind)));
endmodule

bind sio_ddr_sram sio_ddr_sram_chk #(.W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .term_mode(term_mode),
  .rd_oe(rd_oe), .rd_data(rd_data), .wr_commit(wr_commit),
  .head_kind(head_kind), .tail_kind(tail_kind), .out_kind(out_kind)
);

// File: tb/sio_ddr_sram_bench.sv
`timescale 1ns/1ps
module sio_ddr_sram_bench;
  localparam int AW = 4;
  localparam int W  = 8;
  localparam int RL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [1:0]    term_mode = 2'b00;
  logic [W-1:0]  rd_data;
  logic          rd_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sio_ddr_sram #(.ADDR_W(AW), .BEAT_W(W), .RD_LAT(RL)) u_sio_ddr_sram (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .rd_addr(rd_addr),
    .wr_addr(wr_addr), .wr_data(wr_data), .term_mode(term_mode),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  // Bench-side model: array of two-beat words and per-cycle expectations
  logic [2*W-1:0] mdl [1<<AW];
  logic           e_oe [256];
  logic [W-1:0]   e_b0 [256];
  logic [W-1:0]   e_b1 [256];
  int             e_tag [256];
  int             t;

  // Vector: {tag[31:28], rdn[27], wrn[26], ra[25:22], wa[21:18], d0[17:10], d1[9:2], md[1:0]}
  localparam logic [31:0] VEC [16] = '{
    {4'd2,  1'b1, 1'b0, 4'h0, 4'h1, 8'h11, 8'h22, 2'b00}, // R2 write a1
    {4'd7,  1'b1, 1'b0, 4'h0, 4'h2, 8'h33, 8'h44, 2'b01}, // R2 write a2, R7 idle low
    {4'd6,  1'b1, 1'b0, 4'h0, 4'h3, 8'h55, 8'h66, 2'b00}, // R6 write a3, idle released
    {4'd3,  1'b0, 1'b1, 4'h1, 4'h0, 8'h00, 8'h00, 2'b00}, // R3 read a1
    {4'd6,  1'b1, 1'b1, 4'h0, 4'h0, 8'h00, 8'h00, 2'b00}, // R6 nop
    {4'd4,  1'b0, 1'b0, 4'h2, 4'h5, 8'h77, 8'h88, 2'b00}, // R4 read a2 + write a5
    {4'd5,  1'b0, 1'b0, 4'h3, 4'h3, 8'h99, 8'hAA, 2'b00}, // R5 same address, old data
    {4'd5,  1'b0, 1'b1, 4'h3, 4'h0, 8'h00, 8'h00, 2'b00}, // R5 new data now visible
    {4'd7,  1'b1, 1'b1, 4'h1, 4'h1, 8'hFF, 8'hFF, 2'b10}, // R7 nop mode 10, junk on bus
    {4'd8,  1'b1, 1'b1, 4'h1, 4'h1, 8'hEE, 8'hEE, 2'b11}, // R8 reserved mode released
    {4'd4,  1'b0, 1'b1, 4'h5, 4'h0, 8'h00, 8'h00, 2'b00}, // R4 the combined write landed
    {4'd1,  1'b0, 1'b1, 4'h1, 4'h0, 8'h00, 8'h00, 2'b00}, // R1 a1 untouched by nops
    {4'd11, 1'b0, 1'b1, 4'h2, 4'h0, 8'h00, 8'h00, 2'b10}, // R11 read ignores mode
    {4'd11, 1'b1, 1'b1, 4'h0, 4'h0, 8'h00, 8'h00, 2'b00}, // R11 own mode 00 releases
    {4'd10, 1'b0, 1'b1, 4'h3, 4'h0, 8'h00, 8'h00, 2'b00}, // R10 back-to-back reads
    {4'd10, 1'b0, 1'b1, 4'h5, 4'h0, 8'h00, 8'h00, 2'b00}  // R10
  };

  task automatic check(input int tag, input string what, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h (slot %0d)", tag, what, act, exp, t);
    end
  endtask

  // Slots 0..RL-1 after reset release carry no command: released output (R9)
  task automatic init_slots();
    for (int i = 0; i < 256; i++) begin
      e_oe[i] = 1'b0; e_b0[i] = '0; e_b1[i] = '0; e_tag[i] = 9;
    end
    t = 0;
  endtask

  // One cycle: called at falling edge + 2 ns, returns at next falling edge + 2 ns
  task automatic step(input int tag, input logic rdn, input logic wrn,
                      input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                      input logic [W-1:0] d0, input logic [W-1:0] d1, input logic [1:0] md);
    int e;
    rd_n = rdn; wr_n = wrn; rd_addr = ra; term_mode = md; wr_data = d0;
    e = t + RL;
    e_tag[e] = tag;
    if (!rdn) begin
      e_oe[e] = 1'b1; e_b0[e] = mdl[ra][W-1:0]; e_b1[e] = mdl[ra][2*W-1:W];
    end else begin
      e_oe[e] = (md == 2'b01) || (md == 2'b10);
      e_b0[e] = '0; e_b1[e] = '0;
    end
    if (!wrn) mdl[wa] = {d1, d0};
    @(posedge clk); #2;
    check(e_tag[t], "oe", {8'h00, rd_oe}, {8'h00, e_oe[t]});
    check(e_tag[t], "beat0", {1'b0, rd_data}, {1'b0, e_b0[t]});
    wr_addr = wa; wr_data = d1;
    @(negedge clk); #2;
    check(e_tag[t], "beat1", {1'b0, rd_data}, {1'b0, e_b1[t]});
    t++;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    init_slots();
    repeat (3) @(posedge clk);
    #2;
    check(9, "reset oe", {8'h00, rd_oe}, 9'h000);   // R9 output released in reset
    check(9, "reset data", {1'b0, rd_data}, 9'h000);
    @(negedge clk); #2;
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < 16; i++) begin
      step(int'(VEC[i][31:28]), VEC[i][27], VEC[i][26], VEC[i][25:22], VEC[i][21:18],
           VEC[i][17:10], VEC[i][9:2], VEC[i][1:0]);
    end
    for (int i = 0; i <= RL; i++) step(6, 1'b1, 1'b1, '0, '0, '0, '0, 2'b00);

    // Directed: reset in the middle of queued reads (R9), array kept
    step(9, 1'b0, 1'b1, 4'h1, 4'h0, '0, '0, 2'b00);
    step(9, 1'b0, 1'b1, 4'h2, 4'h0, '0, '0, 2'b01);
    rst_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #2;
      check(9, "oe in reset", {8'h00, rd_oe}, 9'h000);
      check(9, "data in reset", {1'b0, rd_data}, 9'h000);
    end
    @(negedge clk); #2;
    rst_n = 1'b1;
    init_slots();
    step(9, 1'b0, 1'b1, 4'h1, 4'h0, '0, '0, 2'b01);   // R9 contents survive reset
    step(7, 1'b1, 1'b0, 4'h0, 4'h6, 8'hC1, 8'hC2, 2'b10);
    step(10, 1'b0, 1'b1, 4'h6, 4'h0, '0, '0, 2'b00);
    for (int i = 0; i <= RL; i++) step(8, 1'b1, 1'b1, '0, '0, '0, '0, 2'b11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule